// File: doc/BRIEF.md
# Multicycle Load, Store and Transfer Executor

This block fetches and runs a small subset of 8-bit accumulator-machine instructions: the three register loads, the three register stores, and the six register-to-register transfers. It talks to a single byte-wide synchronous memory port. The port drives an address, write data and a write enable, and its read data for an address shows up in the cycle after that address was presented. The block holds a 16-bit program counter as two byte halves, plus the accumulator, the two index registers and the stack-pointer byte.

Each instruction takes a fixed number of cycles chosen per addressing mode. The indexed absolute forms take one more cycle when adding the index to the low address byte carries into the high byte. The block pulses `done_o` in the last cycle of every instruction and presents any negative/zero flag update on a separate result interface. It has no flag register of its own. An opcode outside the supported set stops the sequencer for good and raises `illegal_o`.

Top module: `lsx_exec`

## Requirements
- R1: After reset the first fetch address is the `START_PC` parameter (default 0x0200). `done_o`, `mem_we_o`, `flag_upd_o` and `illegal_o` are low. A, X and Y reset to 0x00 and the stack byte resets to 0xFF.
- R2: Immediate loads (0xA9 to A, 0xA2 to X, 0xA0 to Y) take 5 cycles and load the byte that follows the opcode.
- R3: Zero-page loads (0xA5, 0xA6, 0xA4) take 6 cycles. Zero-page stores (0x85 of A, 0x86 of X, 0x84 of Y) take 5 cycles.
- R4: Zero-page indexed loads take 7 cycles and the matching stores take 6. Opcodes 0xB6 and 0x96 add Y; opcodes 0xB5, 0xB4, 0x95 and 0x94 add X. The sum wraps inside page 0x00.
- R5: Absolute loads (0xAD, 0xAE, 0xAC) take 7 cycles and absolute stores (0x8D, 0x8E, 0x8C) take 6. The address operand is low byte first, then high byte.
- R6: Absolute indexed loads take 7 cycles and the matching stores take 6. Each takes one extra cycle when base plus index crosses a 256-byte page. Opcodes 0xBD, 0xBC and 0x9D add X; opcodes 0xB9, 0xBE and 0x99 add Y.
- R7: Transfers take 4 cycles: 0xAA A to X, 0xA8 A to Y, 0xBA stack to X, 0x8A X to A, 0x9A X to stack, 0x98 Y to A.
- R8: In the final cycle of every load and every transfer except 0x9A, `flag_upd_o` is high. In that cycle `flag_n_o` equals bit 7 of the moved value and `flag_z_o` is high exactly when that value is zero. Stores and 0x9A never raise `flag_upd_o`.
- R9: `done_o` is high for exactly the last cycle of each instruction. In the next cycle the fetch address is the byte after the instruction's last operand.
- R10: A store asserts `mem_we_o` for exactly one cycle, its last cycle, with the effective address and the source register's value. `mem_we_o` is never high in any other cycle.
- R11: An opcode outside the supported set sets `illegal_o`. It stays set until reset, and no further `done_o`, `flag_upd_o` or writes occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 16 | Memory address |
| mem_rdata_i | input | 8 | Read data, valid one cycle after its address |
| mem_wdata_o | output | 8 | Write data |
| mem_we_o | output | 1 | Write enable |
| done_o | output | 1 | Last cycle of an instruction |
| flag_upd_o | output | 1 | Negative/zero flag update request |
| flag_n_o | output | 1 | Negative flag value for the update |
| flag_z_o | output | 1 | Zero flag value for the update |
| illegal_o | output | 1 | Unsupported opcode seen; sequencer halted |

## Verification
The assertions check on every cycle the properties that need no program context:
- a write occurs only in a done cycle;
- a flag update occurs only in a done cycle and never alongside a write;
- done never fires twice in a row;
- zero-page accesses stay in page zero;
- the halt is sticky and silent.

Only the bench's instruction stream can show the values that depend on the sequence:
- the exact cycle count per opcode, including the page-cross cycle;
- which index register each opcode uses;
- the effective addresses and the data moved;
- the fetch address that follows each instruction;
- the reset value of the stack byte, seen through a transfer.

// File: rtl/lsx_pkg.sv
`timescale 1ns/1ps
package lsx_pkg;
  localparam int DW   = 8;
  localparam int AW   = 16;
  localparam int NREG = 4;
  localparam int SW   = 4;

  typedef enum logic [2:0] {M_IMP, M_IMM, M_ZP, M_ZPI, M_ABS, M_ABI} mode_e;
  typedef enum logic [1:0] {RG_A, RG_X, RG_Y, RG_S} reg_e;

  typedef struct packed {
    logic  ok;
    mode_e mode;
    logic  store;
    logic  idx_y;
    reg_e  dst;
    reg_e  src;
    logic  set_nz;
  } dec_t;
endpackage

// File: rtl/lsx_decode.sv
`timescale 1ns/1ps
module lsx_decode
  import lsx_pkg::*;
(
  input  logic [DW-1:0] op_i,
  output dec_t          dec_o
);
  always_comb begin
    dec_o = '{ok: 1'b1, mode: M_IMP, store: 1'b0, idx_y: 1'b0,
              dst: RG_A, src: RG_A, set_nz: 1'b1};
    // addressing mode and index choice
    case (op_i)
      8'hA9, 8'hA2, 8'hA0:                      dec_o.mode = M_IMM;
      8'hA5, 8'hA6, 8'hA4, 8'h85, 8'h86, 8'h84: dec_o.mode = M_ZP;
      8'hB5, 8'hB4, 8'h95, 8'h94:               dec_o.mode = M_ZPI;
      8'hB6, 8'h96: begin dec_o.mode = M_ZPI; dec_o.idx_y = 1'b1; end
      8'hAD, 8'hAE, 8'hAC, 8'h8D, 8'h8E, 8'h8C: dec_o.mode = M_ABS;
      8'hBD, 8'hBC, 8'h9D:                      dec_o.mode = M_ABI;
      8'hB9, 8'hBE, 8'h99: begin dec_o.mode = M_ABI; dec_o.idx_y = 1'b1; end
      8'hAA, 8'hA8, 8'hBA, 8'h8A, 8'h9A, 8'h98: dec_o.mode = M_IMP;
      default:                                  dec_o.ok = 1'b0;
    endcase
    // register roles
    case (op_i)
      8'hA9, 8'hA5, 8'hB5, 8'hAD, 8'hBD, 8'hB9: dec_o.dst = RG_A;
      8'hA2, 8'hA6, 8'hB6, 8'hAE, 8'hBE:        dec_o.dst = RG_X;
      8'hA0, 8'hA4, 8'hB4, 8'hAC, 8'hBC:        dec_o.dst = RG_Y;
      8'h85, 8'h95, 8'h8D, 8'h9D, 8'h99: begin
        dec_o.store = 1'b1; dec_o.set_nz = 1'b0; dec_o.src = RG_A;
      end
      8'h86, 8'h96, 8'h8E: begin
        dec_o.store = 1'b1; dec_o.set_nz = 1'b0; dec_o.src = RG_X;
      end
      8'h84, 8'h94, 8'h8C: begin
        dec_o.store = 1'b1; dec_o.set_nz = 1'b0; dec_o.src = RG_Y;
      end
      8'hAA: begin dec_o.src = RG_A; dec_o.dst = RG_X; end
      8'hA8: begin dec_o.src = RG_A; dec_o.dst = RG_Y; end
      8'hBA: begin dec_o.src = RG_S; dec_o.dst = RG_X; end
      8'h8A: begin dec_o.src = RG_X; dec_o.dst = RG_A; end
      8'h9A: begin dec_o.src = RG_X; dec_o.dst = RG_S; dec_o.set_nz = 1'b0; end
      8'h98: begin dec_o.src = RG_Y; dec_o.dst = RG_A; end
      default: ;
    endcase
  end
endmodule

// File: rtl/lsx_regs.sv
`timescale 1ns/1ps
module lsx_regs
  import lsx_pkg::*;
#(
  parameter int            W     = DW,
  parameter logic [W-1:0]  S_RST = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  reg_e         wsel_i,
  input  logic [W-1:0] wval_i,
  input  reg_e         rsel_i,
  input  logic         idx_y_i,
  output logic [W-1:0] rval_o,
  output logic [W-1:0] ival_o
);
  logic [W-1:0] regs_w [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [W-1:0] RV = (g == int'(RG_S)) ? S_RST : '0;
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             q <= RV;
      else if (we_i && int'(wsel_i) == g)      q <= wval_i;
    end
    assign regs_w[g] = q;
  end

  assign rval_o = regs_w[rsel_i];
  assign ival_o = idx_y_i ? regs_w[RG_Y] : regs_w[RG_X];
endmodule

// File: rtl/lsx_exec.sv
`timescale 1ns/1ps
module lsx_exec
  import lsx_pkg::*;
#(
  parameter logic [AW-1:0] START_PC = 16'h0200
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  output logic          done_o,
  output logic          flag_upd_o,
  output logic          flag_n_o,
  output logic          flag_z_o,
  output logic          illegal_o
);
  localparam int HW = AW - DW;

  logic [SW-1:0] step_q, acc_step, last_step;
  logic [DW-1:0] pcl_q, pch_q, adl_q, adh_q, opnd_q;
  logic          cross_q, halt_q;
  dec_t          dec_q, dec_w;
  logic          run, is_mem, done_w, acc_w, pc_inc;
  logic [DW-1:0] rval_w, ival_w, cval_w;
  logic [DW:0]   idx_sum;

  lsx_decode u_dec (.op_i(mem_rdata_i), .dec_o(dec_w));

  lsx_regs #(.W(DW), .S_RST(8'hFF)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (done_w && !dec_q.store),
    .wsel_i  (dec_q.dst),
    .wval_i  (cval_w),
    .rsel_i  (dec_q.src),
    .idx_y_i (dec_q.idx_y),
    .rval_o  (rval_w),
    .ival_o  (ival_w)
  );

  assign run     = !halt_q;
  assign is_mem  = dec_q.mode inside {M_ZP, M_ZPI, M_ABS, M_ABI};
  assign idx_sum = {1'b0, mem_rdata_i} + {1'b0, ival_w};

  always_comb begin
    case (dec_q.mode)
      M_ZP:         acc_step = SW'(4);
      M_ZPI, M_ABS: acc_step = SW'(5);
      M_ABI:        acc_step = SW'(5) + SW'(cross_q);
      default:      acc_step = '0;
    endcase
    case (dec_q.mode)
      M_IMP:   last_step = SW'(3);
      M_IMM:   last_step = SW'(4);
      default: last_step = dec_q.store ? acc_step : acc_step + SW'(1);
    endcase
  end

  // steps 0 and 1 belong to the fetch; dec_q is stale there
  assign done_w = run && step_q >= SW'(2) && step_q == last_step;
  assign acc_w  = run && is_mem && step_q >= SW'(2) && step_q == acc_step;
  assign pc_inc = run && (step_q == SW'(0)
                  || (step_q == SW'(2) && dec_q.mode != M_IMP)
                  || (step_q == SW'(3) && dec_q.mode inside {M_ABS, M_ABI}));

  always_comb begin
    case (dec_q.mode)
      M_IMM:   cval_w = opnd_q;
      M_IMP:   cval_w = rval_w;
      default: cval_w = mem_rdata_i;
    endcase
  end

  assign mem_addr_o  = acc_w ? {adh_q, adl_q} : {pch_q, pcl_q};
  assign mem_wdata_o = rval_w;
  assign mem_we_o    = acc_w && dec_q.store;
  assign done_o      = done_w;
  assign flag_upd_o  = done_w && dec_q.set_nz;
  assign flag_n_o    = flag_upd_o && cval_w[DW-1];
  assign flag_z_o    = flag_upd_o && (cval_w == '0);
  assign illegal_o   = halt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q  <= '0;
      {pch_q, pcl_q} <= START_PC;
      adl_q   <= '0;
      adh_q   <= '0;
      opnd_q  <= '0;
      cross_q <= 1'b0;
      halt_q  <= 1'b0;
      dec_q   <= '0;
    end else if (run) begin
      if (pc_inc) {pch_q, pcl_q} <= {pch_q, pcl_q} + AW'(1);
      case (step_q)
        SW'(1): begin
          dec_q   <= dec_w;
          cross_q <= 1'b0;
          if (!dec_w.ok) halt_q <= 1'b1;
        end
        SW'(3): begin
          case (dec_q.mode)
            M_IMM: opnd_q <= mem_rdata_i;
            M_ZP:  begin adl_q <= mem_rdata_i;      adh_q <= '0; end
            M_ZPI: begin adl_q <= idx_sum[DW-1:0]; adh_q <= '0; end
            M_ABS: adl_q <= mem_rdata_i;
            M_ABI: {cross_q, adl_q} <= idx_sum;
            default: ;
          endcase
        end
        SW'(4): begin
          if (dec_q.mode == M_ABS) adh_q <= mem_rdata_i;
          if (dec_q.mode == M_ABI) adh_q <= mem_rdata_i + DW'(cross_q);
        end
        default: ;
      endcase
      step_q <= done_w ? '0 : step_q + SW'(1);
    end
  end

  a_r10_we_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> done_o) else $error("write outside final cycle");
  a_r8_upd_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_upd_o |-> done_o) else $error("flag update outside final cycle");
  a_r8_store_no_upd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !flag_upd_o) else $error("store requested flag update");
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("done held two cycles");
  a_r4_zp_page0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_w && dec_q.mode inside {M_ZP, M_ZPI}) |-> mem_addr_o[AW-1:DW] == HW'(0))
    else $error("zero-page access left page zero");
  a_r11_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> illegal_o) else $error("halt released");
  a_r11_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!done_o && !mem_we_o && !flag_upd_o)) else $error("activity while halted");
  a_r11_exec_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || mem_we_o) |-> dec_q.ok) else $error("unsupported opcode executed");
endmodule

// File: tb/lsx_exec_bench.sv
`timescale 1ns/1ps
module lsx_exec_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;
  logic rst_ni = 1'b0;

  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata, mem_wdata;
  logic        mem_we, done, fupd, fn, fz, illegal;

  lsx_exec u_lsx_exec (
    .clk_i(clk), .rst_ni(rst_ni), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .mem_wdata_o(mem_wdata), .mem_we_o(mem_we), .done_o(done), .flag_upd_o(fupd),
    .flag_n_o(fn), .flag_z_o(fz), .illegal_o(illegal)
  );

  logic [7:0] mem [4096];
  logic [7:0] sh  [4096];

  always @(posedge clk) begin
    if (!rst_ni) begin
      for (int i = 0; i < 4096; i++) mem[i] <= sh[i];
    end else begin
      if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[11:0]];
    end
  end

  typedef struct {
    int          cyc;
    bit          st;
    logic [15:0] ad;
    logic [7:0]  dt;
    bit          upd;
    logic [7:0]  val;
    logic [15:0] nxt;
    string       req;
  } exp_t;

  exp_t        q[$];
  exp_t        me;
  logic [7:0]  r [4];
  logic [15:0] pb;
  int          n_cmp = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic emit(input logic [7:0] b);
    sh[pb[11:0]] = b;
    pb++;
  endtask

  task automatic push(input int cyc, input bit st, input logic [15:0] ad,
                      input logic [7:0] dt, input bit upd, input logic [7:0] val,
                      input string req);
    exp_t e;
    e.cyc = cyc; e.st = st; e.ad = ad; e.dt = dt;
    e.upd = upd; e.val = val; e.nxt = pb; e.req = req;
    q.push_back(e);
  endtask

  // mode: 1 zp, 2 zp indexed, 3 abs, 4 abs indexed
  task automatic operand(input int mode, input int idx, input logic [15:0] arg,
                         output logic [15:0] ea, output bit cr);
    cr = 1'b0;
    case (mode)
      1: ea = {8'h00, arg[7:0]};
      2: ea = {8'h00, 8'(arg[7:0] + r[idx])};
      3: ea = arg;
      default: begin ea = arg + {8'h00, r[idx]}; cr = (ea[15:8] != arg[15:8]); end
    endcase
    emit(arg[7:0]);
    if (mode >= 3) emit(arg[15:8]);
  endtask

  task automatic ld(input logic [7:0] opc, input int mode, input int dst,
                    input int idx, input logic [15:0] arg, input string req);
    logic [15:0] ea; bit cr; logic [7:0] v; int cyc;
    emit(opc);
    if (mode == 0) begin
      emit(arg[7:0]); v = arg[7:0]; cyc = 5;
    end else begin
      operand(mode, idx, arg, ea, cr);
      v = sh[ea[11:0]];
      cyc = (mode == 1) ? 6 : 7 + int'(cr);
    end
    r[dst] = v;
    push(cyc, 1'b0, '0, '0, 1'b1, v, req);
  endtask

  task automatic st(input logic [7:0] opc, input int mode, input int src,
                    input int idx, input logic [15:0] arg, input string req);
    logic [15:0] ea; bit cr; int cyc;
    emit(opc);
    operand(mode, idx, arg, ea, cr);
    cyc = (mode == 1) ? 5 : 6 + int'(cr);
    sh[ea[11:0]] = r[src];
    push(cyc, 1'b1, ea, r[src], 1'b0, '0, req);
  endtask

  task automatic xf(input logic [7:0] opc, input int src, input int dst, input string req);
    emit(opc);
    r[dst] = r[src];
    push(4, 1'b0, '0, '0, dst != 3, r[src], req);
  endtask

  // monitor: pops one expected item per done pulse
  int cnt = 0;
  bit chk_nxt = 1'b0;
  logic [15:0] nxt_e;
  always @(negedge clk) begin
    if (rst_ni) begin
      cnt++;
      if (chk_nxt) begin
        chk(mem_addr == nxt_e, "R9", "next fetch address", mem_addr, nxt_e);
        chk_nxt = 1'b0;
      end
      if (mem_we && !done) chk(1'b0, "R10", "write outside final cycle", 1, 0);
      if (illegal && q.size() != 0) chk(1'b0, "R11", "halt before end of program", 1, 0);
      if (done) begin
        if (q.size() == 0) chk(1'b0, "R11", "done after halt", 1, 0);
        else begin
          me = q.pop_front();
          chk(cnt == me.cyc, me.req, "cycle count", cnt, me.cyc);
          chk(mem_we == me.st, "R10", "write enable", mem_we, me.st);
          if (me.st) begin
            chk(mem_addr == me.ad, me.req, "store address", mem_addr, me.ad);
            chk(mem_wdata == me.dt, me.req, "store data", mem_wdata, me.dt);
          end
          chk(fupd == me.upd, "R8", "flag update", fupd, me.upd);
          if (me.upd) begin
            chk(fn == me.val[7], me.req, "negative flag", fn, me.val[7]);
            chk(fz == (me.val == 8'h00), me.req, "zero flag", fz, me.val == 8'h00);
          end
          nxt_e = me.nxt;
          chk_nxt = 1'b1;
        end
        cnt = 0;
      end
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) sh[i] = 8'h00;
    r[0] = 8'h00; r[1] = 8'h00; r[2] = 8'h00; r[3] = 8'hFF;
    pb = 16'h0200;
    sh[12'h020] = 8'h42; sh[12'h022] = 8'h91; sh[12'h033] = 8'h11;
    sh[12'h001] = 8'h77; sh[12'h0B7] = 8'h5A; sh[12'h345] = 8'h80;
    sh[12'h346] = 8'h02; sh[12'h347] = 8'h01; sh[12'h312] = 8'h33;
    sh[12'h320] = 8'hC3;

    xf(8'hBA, 3, 1, "R1");              // stack reset value into X
    st(8'h86, 1, 1, 0, 16'h0010, "R3");
    ld(8'hA9, 0, 0, 0, 16'h0000, "R2");
    ld(8'hA2, 0, 1, 0, 16'h0005, "R2");
    ld(8'hA0, 0, 2, 0, 16'h0080, "R2");
    ld(8'hA5, 1, 0, 0, 16'h0020, "R3");
    ld(8'hA6, 1, 1, 0, 16'h0021, "R3");
    ld(8'hA4, 1, 2, 0, 16'h0022, "R3");
    ld(8'hA2, 0, 1, 0, 16'h0003, "R2");
    ld(8'hA0, 0, 2, 0, 16'h0004, "R2");
    ld(8'hB5, 2, 0, 1, 16'h0030, "R4");
    ld(8'hB4, 2, 2, 1, 16'h00FE, "R4"); // wraps to 0x01
    ld(8'hB6, 2, 1, 2, 16'h0040, "R4"); // indexed by Y
    st(8'h95, 2, 0, 1, 16'h0010, "R4");
    st(8'h96, 2, 1, 2, 16'h0095, "R4"); // wraps to 0x0C
    st(8'h94, 2, 2, 1, 16'h0000, "R4");
    st(8'h85, 1, 0, 0, 16'h0050, "R3");
    st(8'h84, 1, 2, 0, 16'h0051, "R3");
    ld(8'hAD, 3, 0, 0, 16'h0345, "R5");
    ld(8'hAE, 3, 1, 0, 16'h0346, "R5");
    ld(8'hAC, 3, 2, 0, 16'h0347, "R5");
    st(8'h8D, 3, 0, 0, 16'h0400, "R5");
    st(8'h8E, 3, 1, 0, 16'h0401, "R5");
    st(8'h8C, 3, 2, 0, 16'h0402, "R5");
    ld(8'hBD, 4, 0, 1, 16'h0310, "R6");
    ld(8'hB9, 4, 0, 2, 16'h03FF, "R6"); // crosses
    ld(8'hBC, 4, 2, 1, 16'h04FE, "R6"); // crosses
    ld(8'hBE, 4, 1, 2, 16'h0320, "R6");
    st(8'h9D, 4, 0, 1, 16'h0440, "R6"); // crosses
    st(8'h99, 4, 0, 2, 16'h0450, "R6");
    ld(8'hA0, 0, 2, 0, 16'h0020, "R2");
    st(8'h99, 4, 0, 2, 16'h06F0, "R6"); // crosses
    ld(8'hA9, 0, 0, 0, 16'h009C, "R2");
    xf(8'hAA, 0, 1, "R7");
    ld(8'hA9, 0, 0, 0, 16'h0000, "R2");
    xf(8'hA8, 0, 2, "R7");
    xf(8'h8A, 1, 0, "R7");
    xf(8'h9A, 1, 3, "R7");              // no flag update
    ld(8'hA2, 0, 1, 0, 16'h0001, "R2");
    xf(8'hBA, 3, 1, "R7");
    ld(8'hA0, 0, 2, 0, 16'h007F, "R2");
    xf(8'h98, 2, 0, "R7");
    st(8'h85, 1, 0, 0, 16'h0060, "R10");
    emit(8'h02);                        // unsupported opcode

    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    chk(mem_addr == 16'h0200, "R1", "first fetch address", mem_addr, 16'h0200);
    chk(!done && !mem_we && !fupd, "R1", "quiet after reset", {done, mem_we, fupd}, 0);
    chk(illegal == 1'b0, "R1", "illegal after reset", illegal, 0);

    for (int i = 0; i < 20000 && q.size() != 0; i++) @(negedge clk);
    if (q.size() != 0) chk(1'b0, "WDOG", "watchdog expired, items left", q.size(), 0);

    repeat (20) @(negedge clk);
    chk(illegal == 1'b1, "R11", "illegal flag", illegal, 1);
    begin
      int diff = 0;
      for (int i = 0; i < 4096; i++) if (mem[i] !== sh[i]) diff++;
      chk(diff == 0, "R10", "memory image mismatched bytes", diff, 0);
    end
    chk(mem[12'h00C] == 8'h5A, "R4", "wrapped zero-page store", mem[12'h00C], 8'h5A);
    chk(mem[12'h503] == 8'h80, "R6", "page-crossing store", mem[12'h503], 8'h80);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule